// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the serial-side controller of a 256-byte nonvolatile memory that answers on a two-wire bus. The storage is modelled as a register array with an erased value of all ones. The block receives SCL and SDA levels that have already been filtered and synchronised, together with one-cycle strobes that mark start and stop conditions. It also takes three strap pins that select its bus address and a write-protect input. Its only output is a pull-down enable for the open-drain SDA line.

A write names a word address and then streams up to eight data bytes into a page buffer. The bytes reach the array only after a stop, at the end of an internal write cycle whose length is a parameter in system clocks. While that cycle runs the block stays off the bus, so a master polls it with its device address until it acknowledges again. Reads start at an internal address counter, either where the last access left it or where a dummy write placed it, and continue for as long as the master acknowledges.

Top module: `eeprom_serial_slave`

## Requirements
- R1: The first byte after a start is the device address, received MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal addr_pins[2:0]. On a match the block pulls SDA low for the ninth SCL clock. Bit 0 set to 1 selects a read and bit 0 cleared to 0 selects a write.
- R2: On a device-address mismatch the block gives no acknowledge and leaves SDA released for every byte that follows, until the next start.
- R3: Received bits are sampled on the SCL rising edge. sda_pull changes only while SCL is low, one clock after a falling edge, or on a start or stop strobe.
- R4: A write is the device address, the word address and one to eight data bytes, each acknowledged. The data bytes fill consecutive locations whose low three address bits wrap within the 8-byte page, so a ninth byte overwrites the first. A stop after a data byte's acknowledge commits every buffered byte.
- R5: After such a stop the block stays busy for WR_CYCLES clocks. While busy it acknowledges nothing, not even its own device address, and it acknowledges again once the cycle ends.
- R6: While wp_in is 1 the device and word address bytes are acknowledged, data bytes are not, no write cycle starts and the array is unchanged. While wp_in is 0 writes behave as in R4.
- R7: After a read-mode device address is acknowledged, the byte at the address counter is shifted out MSB first.
- R8: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte, with the address wrapping from 255 to 0. A master no-acknowledge followed by a stop ends the read.
- R9: The address counter holds the last accessed location plus one. After a write this is the last written location plus one, wrapped within its page. After a read it is the last sent byte plus one.
- R10: A random read is a write that stops, or restarts, after the word address. It starts no write cycle, and the read-mode device address that follows returns the byte at that word address.
- R11: A start or stop in the middle of a byte abandons the transfer. A stop that ends a write with no complete data byte starts no write cycle.
- R12: After reset sda_pull is 0, the block is not busy, the address counter is 0 and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised, filtered SCL level |
| sda_in | input | 1 | Synchronised, filtered SDA level |
| start_pulse | input | 1 | One-cycle strobe for a start condition |
| stop_pulse | input | 1 | One-cycle strobe for a stop condition |
| addr_pins | input | 3 | Strapped device-address bits |
| wp_in | input | 1 | Write protect for the whole array, active high |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |

## Verification
Some properties are checked on every cycle by assertions:
- SDA only moves after a falling SCL edge or a bus strobe.
- The line stays released in idle, in the ignore state and during the whole write cycle.
- A write cycle only begins right after a stop.
- The busy window lasts exactly WR_CYCLES clocks.

Other properties are data-dependent and only the directed scenarios can show them:
- Page wrap and overwrite order, and commit of the buffered bytes.
- The address counter value after writes and reads, and the 255-to-0 wrap during a sequential read.
- Acknowledge polling, and the write-protect and abort cases that leave the array at its erased value.

// File: rtl/eepr_pkg.sv
package eepr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_DEV, ST_ADDR, ST_DATA, ST_ACK, ST_READ, ST_RACK, ST_WAIT
   } link_st_t;
endpackage

// File: rtl/eepr_scl_edges.sv
module eepr_scl_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   output logic rise,
   output logic fall
);
   logic scl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_in;
   end
   assign rise = scl_in & ~scl_q;
   assign fall = ~scl_in & scl_q;
endmodule

// File: rtl/eepr_wr_timer.sv
module eepr_wr_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_len
      $error("eepr_wr_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] left;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  left <= '0;
      else if (go && left == '0)   left <= CW'(CYCLES);
      else if (left != '0)         left <= left - CW'(1);
   end
   assign busy = (left != '0);
   assign done = (left == CW'(1));

   // checker: length of each busy window
   logic [CW:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seen <= '0;
      else if (!busy) seen <= '0;
      else            seen <= seen + (CW+1)'(1);
   end
   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> seen == (CW+1)'(CYCLES));
endmodule

// File: rtl/eepr_page_buf.sv
module eepr_page_buf #(
   parameter int LANE_W = 3,
   parameter int LANES  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic [LANE_W-1:0]  lane,
   input  logic [7:0]         wdata,
   output logic [LANES*8-1:0] lane_data,
   output logic [LANES-1:0]   lane_vld
);
   if (LANES != (1 << LANE_W)) begin : g_bad_lanes
      $error("eepr_page_buf: LANES must equal 2**LANE_W");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] q;
      logic       v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
            v <= 1'b0;
         end else if (clr) begin
            v <= 1'b0;
         end else if (wr && lane == LANE_W'(g)) begin
            q <= wdata;
            v <= 1'b1;
         end
      end
      assign lane_data[g*8 +: 8] = q;
      assign lane_vld[g]         = v;
   end
endmodule

// File: rtl/eepr_cell_array.sv
module eepr_cell_array #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [(1<<PAGE_W)-1:0]      we,
   input  logic [ADDR_W-PAGE_W-1:0]    row,
   input  logic [(1<<PAGE_W)*8-1:0]    wdata,
   input  logic [ADDR_W-1:0]           raddr,
   output logic [7:0]                  rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = 1 << PAGE_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[ADDR_W'(a)] <= 8'hFF;
      end else begin
         for (int l = 0; l < LANES; l++)
            if (we[l]) mem[{row, PAGE_W'(l)}] <= wdata[l*8 +: 8];
      end
   end
   assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
   import eepr_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         PAGE_W    = 3,
   parameter int         WR_CYCLES = 1000,
   parameter logic [3:0] DEV_CODE  = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic       start_pulse,
   input  logic       stop_pulse,
   input  logic [2:0] addr_pins,
   input  logic       wp_in,
   output logic       sda_pull
);
   localparam int LANES = 1 << PAGE_W;
   localparam int ROW_W = ADDR_W - PAGE_W;

   if (ADDR_W > 8 || PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_cfg
      $error("eeprom_serial_slave: need 1 <= PAGE_W < ADDR_W <= 8");
   end

   link_st_t            state, nxt;
   logic [3:0]          cnt;
   logic [7:0]          sr, osr;
   logic [ADDR_W-1:0]   ptr;
   logic                has_data, cont;
   logic                scl_rise, scl_fall, wr_busy, wr_done, wr_go;
   logic                fall_ok, byte_done, dev_hit, buf_clr, buf_wr;
   logic [LANES*8-1:0]  lane_data;
   logic [LANES-1:0]    lane_vld, we_lanes;
   logic [7:0]          rd_data;

   eepr_scl_edges u_edges (.clk, .rst_n, .scl_in, .rise(scl_rise), .fall(scl_fall));

   eepr_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk, .rst_n, .go(wr_go), .busy(wr_busy), .done(wr_done));

   eepr_page_buf #(.LANE_W(PAGE_W), .LANES(LANES)) u_buf (
      .clk, .rst_n, .clr(buf_clr), .wr(buf_wr), .lane(ptr[PAGE_W-1:0]),
      .wdata(sr), .lane_data, .lane_vld);

   eepr_cell_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
      .clk, .rst_n, .we(we_lanes), .row(ptr[ADDR_W-1:PAGE_W]),
      .wdata(lane_data), .raddr(ptr), .rdata(rd_data));

   assign fall_ok   = scl_fall & ~wr_busy & ~start_pulse & ~stop_pulse;
   assign byte_done = (cnt == 4'd8);
   assign dev_hit   = (sr[7:4] == DEV_CODE) && (sr[3:1] == addr_pins);
   assign buf_clr   = fall_ok && state == ST_ADDR && byte_done;
   assign buf_wr    = fall_ok && state == ST_DATA && byte_done && !wp_in;
   assign wr_go     = stop_pulse && !wr_busy && state == ST_DATA
                      && cnt <= 4'd1 && has_data;
   assign we_lanes  = lane_vld & {LANES{wr_done}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  nxt <= ST_IDLE;  cnt <= '0;
         sr <= '0;  osr <= '0;  ptr <= '0;
         has_data <= 1'b0;  cont <= 1'b0;  sda_pull <= 1'b0;
      end else if (wr_busy) begin
         state <= ST_IDLE;  sda_pull <= 1'b0;
      end else if (start_pulse) begin
         state <= ST_DEV;  cnt <= '0;  has_data <= 1'b0;  sda_pull <= 1'b0;
      end else if (stop_pulse) begin
         state <= ST_IDLE; cnt <= '0;  has_data <= 1'b0;  sda_pull <= 1'b0;
      end else if (scl_rise) begin
         if ((state == ST_DEV || state == ST_ADDR || state == ST_DATA) && cnt < 4'd8) begin
            sr  <= {sr[6:0], sda_in};
            cnt <= cnt + 4'd1;
         end else if (state == ST_RACK) begin
            cont <= ~sda_in;
         end
      end else if (scl_fall) begin
         case (state)
            ST_DEV: if (byte_done) begin
               cnt <= '0;
               if (dev_hit) begin
                  sda_pull <= 1'b1;  state <= ST_ACK;
                  nxt <= sr[0] ? ST_READ : ST_ADDR;
               end else state <= ST_WAIT;
            end
            ST_ADDR: if (byte_done) begin
               cnt <= '0;  ptr <= sr[ADDR_W-1:0];
               sda_pull <= 1'b1;  state <= ST_ACK;  nxt <= ST_DATA;
            end
            ST_DATA: if (byte_done) begin
               cnt <= '0;
               if (!wp_in) begin
                  ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                  has_data <= 1'b1;  sda_pull <= 1'b1;
                  state <= ST_ACK;  nxt <= ST_DATA;
               end else state <= ST_WAIT;
            end
            ST_ACK: begin
               cnt <= '0;  state <= nxt;
               if (nxt == ST_READ) begin
                  osr <= rd_data;  sda_pull <= ~rd_data[7];
               end else sda_pull <= 1'b0;
            end
            ST_READ: if (cnt == 4'd7) begin
               sda_pull <= 1'b0;  ptr <= ptr + ADDR_W'(1);  state <= ST_RACK;
            end else begin
               osr <= {osr[6:0], 1'b0};  sda_pull <= ~osr[6];  cnt <= cnt + 4'd1;
            end
            ST_RACK: if (cont) begin
               osr <= rd_data;  sda_pull <= ~rd_data[7];  cnt <= '0;  state <= ST_READ;
            end else state <= ST_WAIT;
            default: ;
         endcase
      end
   end

   // R3
   sda_pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall || start_pulse || stop_pulse));
   // R2
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull);
   // R5
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |-> !sda_pull);
   // R11
   commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(stop_pulse));
endmodule

// File: tb/sim_eeprom_serial_slave.sv
module sim_eeprom_serial_slave;
   localparam int WRC = 300;
   localparam logic [7:0] DEV_W = 8'hAA;   // 1010 101 0
   localparam logic [7:0] DEV_R = 8'hAB;   // 1010 101 1

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, sda_drv = 1'b1, start_p = 1'b0, stop_p = 1'b0, wp = 1'b0;
   logic [2:0] pins = 3'b101;
   logic sda_pull, sda_line;
   int checks = 0, errors = 0, r3_viol = 0;
   logic pull_prev = 1'b0;
   logic [7:0] rb [0:15];

   always #2.5 clk = ~clk;
   assign sda_line = sda_drv & ~sda_pull;

   eeprom_serial_slave #(.WR_CYCLES(WRC)) u0 (
      .clk, .rst_n, .scl_in(scl), .sda_in(sda_line), .start_pulse(start_p),
      .stop_pulse(stop_p), .addr_pins(pins), .wp_in(wp), .sda_pull);

   // R3 monitor: the pull may only move while SCL is low
   always @(negedge clk) begin
      if (rst_n && sda_pull !== pull_prev && scl) r3_viol++;
      pull_prev = sda_pull;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cw(input int n); repeat (n) @(negedge clk); endtask

   task automatic bus_start;
      sda_drv = 1'b1; cw(2); scl = 1'b1; cw(2);
      sda_drv = 1'b0; start_p = 1'b1; cw(1); start_p = 1'b0; cw(2);
      scl = 1'b0; cw(2);
   endtask

   task automatic bus_stop;
      sda_drv = 1'b0; cw(2); scl = 1'b1; cw(2);
      sda_drv = 1'b1; stop_p = 1'b1; cw(1); stop_p = 1'b0; cw(2);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; cw(2); scl = 1'b1; cw(3); scl = 1'b0; cw(2);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_drv = 1'b1; cw(2); scl = 1'b1; cw(2);
      ack = !sda_line; cw(1); scl = 1'b0; cw(2);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_drv = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         cw(2); scl = 1'b1; cw(2); b[i] = sda_line; cw(1); scl = 1'b0;
      end
      cw(1); sda_drv = !mack; cw(1); scl = 1'b1; cw(3); scl = 1'b0; cw(2);
      sda_drv = 1'b1;
   endtask

   task automatic poll_ready(output int tries);
      bit a;
      tries = 99;
      for (int t = 0; t < 60; t++) begin
         bus_start; send_byte(DEV_W, a); bus_stop;
         if (a) begin tries = t + 1; break; end
      end
   endtask

   task automatic rand_read(input logic [7:0] addr, input int n);
      bit a;
      bus_start; send_byte(DEV_W, a); send_byte(addr, a);
      bus_start; send_byte(DEV_R, a);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
      bus_stop;
   endtask

   task automatic cur_read(output logic [7:0] b, output bit a);
      bus_start; send_byte(DEV_R, a); recv_byte(1'b0, b); bus_stop;
   endtask

   task automatic write_one(input logic [7:0] addr, input logic [7:0] d);
      bit a; int t;
      bus_start; send_byte(DEV_W, a); send_byte(addr, a); send_byte(d, a);
      bus_stop; poll_ready(t);
   endtask

   task automatic t_reset;
      logic [7:0] b; bit a;
      chk("R12 pull after reset", sda_pull, 1'b0);
      cur_read(b, a);
      chk("R1 read address acked", a, 1'b1);
      chk("R12 erased byte at counter 0", b, 8'hFF);
   endtask

   task automatic t_bad_addr;
      bit a;
      bus_start; send_byte(8'hA0, a);
      chk("R2 pin mismatch nack", a, 1'b0);
      send_byte(8'h00, a);
      chk("R2 following byte ignored", a, 1'b0);
      bus_stop;
      bus_start; send_byte(8'h2A, a);
      chk("R2 family code mismatch nack", a, 1'b0);
      bus_stop;
   endtask

   task automatic t_byte_write;
      bit a0, a1, a2, ap; int t;
      bus_start; send_byte(DEV_W, a0); send_byte(8'h10, a1); send_byte(8'h5A, a2);
      chk("R4 dev ack", a0, 1'b1); chk("R4 word addr ack", a1, 1'b1);
      chk("R4 data ack", a2, 1'b1);
      bus_stop;
      bus_start; send_byte(DEV_W, ap); bus_stop;
      chk("R5 nack while busy", ap, 1'b0);
      poll_ready(t);
      chk("R5 ack after write cycle", (t < 60) ? 1 : 0, 1);
      rand_read(8'h10, 1);
      chk("R10 random read of written byte", rb[0], 8'h5A);
   endtask

   task automatic t_page_write;
      bit a; int t; logic [7:0] b;
      logic [7:0] exp [0:8] = '{8'h35, 8'h36, 8'h37, 8'h38, 8'h39, 8'h32, 8'h33, 8'h34, 8'hFF};
      bus_start; send_byte(DEV_W, a); send_byte(8'h23, a);
      for (int i = 0; i < 10; i++) send_byte(8'h30 + 8'(i), a);
      chk("R4 tenth data byte acked", a, 1'b1);
      bus_stop; poll_ready(t);
      cur_read(b, a);
      chk("R9 counter after page write", b, 8'h32);
      cur_read(b, a);
      chk("R9 counter after read", b, 8'h33);
      rand_read(8'h20, 9);
      for (int i = 0; i < 9; i++) chk($sformatf("R4 page wrap byte %0d", i), rb[i], exp[i]);
   endtask

   task automatic t_protect;
      bit a0, a1, a2, ap;
      wp = 1'b1;
      bus_start; send_byte(DEV_W, a0); send_byte(8'h40, a1); send_byte(8'h77, a2);
      bus_stop;
      chk("R6 dev ack under protect", a0, 1'b1);
      chk("R6 addr ack under protect", a1, 1'b1);
      chk("R6 data nack under protect", a2, 1'b0);
      bus_start; send_byte(DEV_W, ap); bus_stop;
      chk("R6 no write cycle under protect", ap, 1'b1);
      rand_read(8'h40, 1);
      chk("R6 array unchanged", rb[0], 8'hFF);
      wp = 1'b0;
   endtask

   task automatic t_abort;
      bit a, ap;
      bus_start; send_byte(DEV_W, a); send_byte(8'h50, a); send_byte(8'h11, a);
      send_bits(8'h22, 4); bus_stop;
      bus_start; send_byte(DEV_W, ap); bus_stop;
      chk("R11 mid-byte stop starts no cycle", ap, 1'b1);
      rand_read(8'h50, 1);
      chk("R11 aborted write not committed", rb[0], 8'hFF);
   endtask

   task automatic t_wrap_read;
      write_one(8'hFF, 8'hA1);
      write_one(8'h00, 8'h3C);
      rand_read(8'hFF, 2);
      chk("R7 first byte at 0xFF", rb[0], 8'hA1);
      chk("R8 sequential wrap to 0x00", rb[1], 8'h3C);
   endtask

   initial begin
      cw(4); rst_n = 1'b1; cw(4);
      t_reset;
      t_bad_addr;
      t_byte_write;
      t_page_write;
      t_protect;
      t_abort;
      t_wrap_read;
      chk("R3 pull changes only while SCL low", r3_viol, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule